// File: doc/BRIEF.md
# Slot-Addressed Control Register Access Unit

This unit gives a host access to a bank of on-chip control registers through a time-division serial frame. Each frame is a round of six word slots, and a serial front end (not part of this block) presents each received word with its slot number. The word in slot 0 is a command. It carries a direction flag and a register address. For a write, the word in slot 1 of the same frame is the new value. Whatever the direction, the unit loads a read-back word that the front end sends in slot 1 of the next frame.

A write does not reach the register bank at once. It is parked in a single staging entry and committed when the round-complete strobe marks the end of the six-slot round. The read-back word is captured at the end of slot 1, before that commit. A write therefore returns the register's previous contents. The unit also builds the outbound status word from live status inputs with no register stage, so it is always current for the frame being sent.

Top module: `regSlotAccess`

## Requirements
- R1: After reset every register in the bank is zero, the read-back word is zero and no write is pending (status bit 15 low).
- R2: The slot 0 word is a command. Bit 15 set means read and bit 15 clear means write. Bits 4:0 select one of up to 32 register addresses.
- R3: On a read command, the read-back word becomes the addressed register's committed contents one clock after the slot 1 word is presented, and it keeps that value through slot 1 of the next frame.
- R4: On a write command, the slot 1 word is staged as a pending write, and the read-back word becomes the register's contents from before the write.
- R5: The bank changes only in the cycle after the round-complete strobe. That strobe commits the staged write and clears the pending flag.
- R6: Status word bit 15 shows that a write is pending. Bits 14:0 equal the live status input in the same cycle.
- R7: An address at or above the implemented register count (24 by default) reads back as zero. A write to such an address is discarded: nothing is staged and no register changes.
- R8: If no command arrives in slot 0 of a frame, that frame's slot 1 word has no effect: the read-back word, the bank and the pending flag are unchanged.
- R9: A read command changes no register and stages no write.
- R10: Bits 14:5 of the command word are ignored. Setting them does not change the direction or the address that is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotValid | input | 1 | A received word is presented this cycle |
| slotIdx | input | 3 | Slot number (0 to 5) of the presented word |
| rxWord | input | 16 | Received slot word |
| roundEnd | input | 1 | One-cycle strobe that marks the end of the six-slot round |
| statusIn | input | 15 | Live status flags from the rest of the chip |
| statusWord | output | 16 | Outbound status word: pending flag and live status |
| rdData | output | 16 | Read-back word for slot 1 of the next frame |
| regOut | output | 384 | Committed register bank, register i at bits i*16 +: 16 |

## Verification
The bench sends a write followed by a read of the same register. It checks that the bank stays unchanged until the round strobe and that the write's own read-back holds the old value. A design that commits at once would show the new value in both places. It also addresses registers past the implemented count, sets the reserved command bits, and sends frames that have no slot 0 command. A design that decodes address bits loosely would alias into real registers, and one that leaves a command active past the round would act on stale commands. A random run compares every cycle against a behavioural model, which catches a read-back latched after the commit rather than before it.

// File: rtl/regSlotPkg.sv
package regSlotPkg;

  localparam logic [2:0] SLOT_CMD  = 3'd0;
  localparam logic [2:0] SLOT_DATA = 3'd1;

  // strobes handed from control to datapath
  typedef struct packed {
    logic takeData;   // slot 1 word arrived with a live command
    logic commit;     // round boundary: apply staged write
  } slotStrobes_t;

endpackage

// File: rtl/regSlotCtrl.sv
module regSlotCtrl
  import regSlotPkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotValid,
  input  logic [2:0]        slotIdx,
  input  logic              cmdFlag,
  input  logic [ADDR_W-1:0] cmdField,
  input  logic              roundEnd,
  output slotStrobes_t      strobes,
  output logic              cmdValid,
  output logic              cmdRead,
  output logic [ADDR_W-1:0] cmdAddr
);

  logic seeCmd;
  logic seeData;

  assign seeCmd  = slotValid && (slotIdx == SLOT_CMD);
  assign seeData = slotValid && (slotIdx == SLOT_DATA);

  always_comb begin
    strobes          = '0;
    strobes.takeData = seeData && cmdValid;
    strobes.commit   = roundEnd;
  end

  // command holding: loaded in slot 0, retired at the round boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdRead  <= 1'b0;
      cmdAddr  <= '0;
    end else if (seeCmd) begin
      cmdValid <= 1'b1;
      cmdRead  <= cmdFlag;
      cmdAddr  <= cmdField;
    end else if (roundEnd) begin
      cmdValid <= 1'b0;
    end
  end

endmodule

// File: rtl/regSlotData.sv
module regSlotData
  import regSlotPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = 24
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  slotStrobes_t               strobes,
  input  logic                       cmdRead,
  input  logic [ADDR_W-1:0]          cmdAddr,
  input  logic [DATA_W-1:0]          rxWord,
  output logic [NUM_REGS*DATA_W-1:0] regOut,
  output logic [DATA_W-1:0]          rdData,
  output logic                       pendValid
);

  localparam int BANK_W = NUM_REGS * DATA_W;

  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;
  logic [DATA_W-1:0] selWord;
  logic              addrInRange;
  logic              stageWrite;

  assign addrInRange = ({1'b0, cmdAddr} < (ADDR_W+1)'(NUM_REGS));
  assign stageWrite  = strobes.takeData && !cmdRead && addrInRange;

  // register bank, one entry per implemented address
  for (genvar g = 0; g < NUM_REGS; g++) begin : gBank
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk) begin
      if (!rstN) word <= '0;
      else if (strobes.commit && pendValid && (pendAddr == MY_ADDR))
        word <= pendData;
    end
    assign regOut[g*DATA_W +: DATA_W] = word;
  end

  // committed-value mux for read-back
  always_comb begin
    selWord = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (cmdAddr == ADDR_W'(i)) selWord = regOut[i*DATA_W +: DATA_W];
    end
  end

  // single staging entry; a new write replaces it after any commit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
    end else if (stageWrite) begin
      pendValid <= 1'b1;
      pendAddr  <= cmdAddr;
      pendData  <= rxWord;
    end else if (strobes.commit) begin
      pendValid <= 1'b0;
    end
  end

  // read-back captured from the bank before this cycle's commit lands
  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strobes.takeData) rdData <= addrInRange ? selWord : '0;
  end

  logic unusedBank;
  assign unusedBank = ^{BANK_W{1'b0}};

endmodule

// File: rtl/regSlotAccess.sv
module regSlotAccess
  import regSlotPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = 24
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       slotValid,
  input  logic [2:0]                 slotIdx,
  input  logic [DATA_W-1:0]          rxWord,
  input  logic                       roundEnd,
  input  logic [DATA_W-2:0]          statusIn,
  output logic [DATA_W-1:0]          statusWord,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_REGS*DATA_W-1:0] regOut
);

  slotStrobes_t      strobes;
  logic              cmdValid;
  logic              cmdRead;
  logic [ADDR_W-1:0] cmdAddr;
  logic              pendValid;

  regSlotCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .slotValid(slotValid),
    .slotIdx  (slotIdx),
    .cmdFlag  (rxWord[DATA_W-1]),
    .cmdField (rxWord[ADDR_W-1:0]),
    .roundEnd (roundEnd),
    .strobes  (strobes),
    .cmdValid (cmdValid),
    .cmdRead  (cmdRead),
    .cmdAddr  (cmdAddr)
  );

  regSlotData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cmdRead  (cmdRead),
    .cmdAddr  (cmdAddr),
    .rxWord   (rxWord),
    .regOut   (regOut),
    .rdData   (rdData),
    .pendValid(pendValid)
  );

  // live status, no register stage
  assign statusWord = {pendValid, statusIn};

endmodule

// File: rtl/regSlotChecker.sv
module regSlotChecker #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = 24
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       slotValid,
  input logic [2:0]                 slotIdx,
  input logic                       roundEnd,
  input logic                       cmdValid,
  input logic                       cmdRead,
  input logic [ADDR_W-1:0]          cmdAddr,
  input logic [DATA_W-1:0]          statusWord,
  input logic [DATA_W-1:0]          rdData,
  input logic [NUM_REGS*DATA_W-1:0] regOut
);

  logic dataSlot;
  assign dataSlot = slotValid && (slotIdx == 3'd1) && cmdValid;

  AST_BANK_HOLDS_MIDROUND: assert property (@(posedge clk) disable iff (!rstN)
    !roundEnd |=> $stable(regOut)); // R5

  AST_PEND_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[DATA_W-1]) |-> $past(dataSlot && !cmdRead)); // R4

  AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    (roundEnd && !dataSlot) |=> !statusWord[DATA_W-1]); // R5

  AST_RDDATA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !dataSlot |=> $stable(rdData)); // R8

  AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (dataSlot && (int'(cmdAddr) >= NUM_REGS)) |=> (rdData == '0)); // R7

  AST_READ_STAGES_NOTHING: assert property (@(posedge clk) disable iff (!rstN)
    (dataSlot && cmdRead && !statusWord[DATA_W-1]) |=> !statusWord[DATA_W-1]); // R9

endmodule

bind regSlotAccess regSlotChecker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .slotValid (slotValid),
  .slotIdx   (slotIdx),
  .roundEnd  (roundEnd),
  .cmdValid  (cmdValid),
  .cmdRead   (cmdRead),
  .cmdAddr   (cmdAddr),
  .statusWord(statusWord),
  .rdData    (rdData),
  .regOut    (regOut)
);

// File: tb/regSlotAccess_tb.sv
`timescale 1ns/1ps
module regSlotAccess_tb;

  localparam int DW = 16;
  localparam int AW = 5;
  localparam int NR = 24;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             slotValid = 1'b0;
  logic [2:0]       slotIdx = '0;
  logic [DW-1:0]    rxWord = '0;
  logic             roundEnd = 1'b0;
  logic [DW-2:0]    statusIn = '0;
  logic [DW-1:0]    statusWord;
  logic [DW-1:0]    rdData;
  logic [NR*DW-1:0] regOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  regSlotAccess #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR)) u_dut (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .slotIdx(slotIdx),
    .rxWord(rxWord), .roundEnd(roundEnd), .statusIn(statusIn),
    .statusWord(statusWord), .rdData(rdData), .regOut(regOut)
  );

  // behavioural reference model
  int  mMem[32];
  bit  mPend;
  int  mPendA, mPendD;
  bit  mCmd, mCmdRd;
  int  mCmdA;
  int  mRd;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 0;
      mPend = 0; mPendA = 0; mPendD = 0;
      mCmd = 0; mCmdRd = 0; mCmdA = 0; mRd = 0;
    end else begin
      bit take, stage;
      int newRd;
      take  = slotValid && slotIdx == 3'd1 && mCmd;
      newRd = (mCmdA < NR) ? mMem[mCmdA] : 0;
      stage = take && !mCmdRd && mCmdA < NR;
      if (roundEnd && mPend) mMem[mPendA] = mPendD;
      if (roundEnd) mPend = 0;
      if (stage) begin mPend = 1; mPendA = mCmdA; mPendD = int'(rxWord); end
      if (take) mRd = newRd;
      if (slotValid && slotIdx == 3'd0) begin
        mCmd = 1; mCmdRd = rxWord[15]; mCmdA = int'(rxWord[4:0]);
      end else if (roundEnd) mCmd = 0;
    end
  end

  function automatic logic [DW-1:0] regAt(input logic [NR*DW-1:0] v, input int i);
    return v[i*DW +: DW];
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (rdData !== DW'(mRd)) begin
        errors++;
        $display("FAIL R3/R4 model rdData act=%h exp=%h", rdData, DW'(mRd));
      end
      if (statusWord !== {mPend, statusIn}) begin
        errors++;
        $display("FAIL R6 model statusWord act=%h exp=%h", statusWord, {mPend, statusIn});
      end
      for (int i = 0; i < NR; i++) begin
        if (regAt(regOut, i) !== DW'(mMem[i])) begin
          errors++;
          $display("FAIL R5 model reg%0d act=%h exp=%h", i, regAt(regOut, i), DW'(mMem[i]));
        end
      end
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one six-slot round plus the round-complete strobe
  task automatic doFrame(input bit hasCmd, input logic [DW-1:0] cmd, input logic [DW-1:0] dat,
                         output logic [DW-1:0] midRd, output logic midPend,
                         output logic [NR*DW-1:0] midRegs);
    for (int s = 0; s < 6; s++) begin
      slotValid = (s == 0) ? hasCmd : 1'b1;
      slotIdx   = 3'(s);
      rxWord    = (s == 0) ? cmd : (s == 1) ? dat : DW'($urandom);
      @(negedge clk);
      if (s == 1) begin
        midRd = rdData; midPend = statusWord[15]; midRegs = regOut;
      end
    end
    slotValid = 1'b0;
    roundEnd  = 1'b1;
    @(negedge clk);
    roundEnd  = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp<=50000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0]    mRdv;
    logic             mP;
    logic [NR*DW-1:0] mR;
    logic [NR*DW-1:0] snap;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdData", rdData, 16'h0000);
    check("R1 pending", {15'd0, statusWord[15]}, 16'h0000);
    check("R1 reg0", regAt(regOut, 0), 16'h0000);
    check("R1 reg23", regAt(regOut, 23), 16'h0000);

    // R6 live status
    statusIn = 15'h2A5A; #1;
    check("R6 status bits", {1'b0, statusWord[14:0]}, 16'h2A5A);
    @(negedge clk);

    // R4/R5 write 0x1234 to reg 3: staged, old value returned, commit at boundary
    doFrame(1, 16'h0003, 16'h1234, mRdv, mP, mR);
    check("R4 write returns old", mRdv, 16'h0000);
    check("R4 write pending", {15'd0, mP}, 16'h0001);
    check("R5 not yet committed", regAt(mR, 3), 16'h0000);
    check("R5 committed after round", regAt(regOut, 3), 16'h1234);
    check("R5 pending cleared", {15'd0, statusWord[15]}, 16'h0000);

    // R2/R3 read reg 3
    snap = regOut;
    doFrame(1, 16'h8003, 16'hFFFF, mRdv, mP, mR);
    check("R3 read value", mRdv, 16'h1234);
    check("R3 held into next frame", rdData, 16'h1234);
    check("R9 read stages nothing", {15'd0, mP}, 16'h0000);
    checks++;
    if (regOut !== snap) begin errors++; $display("FAIL R9 bank changed by read act=%h exp=%h", regOut[63:0], snap[63:0]); end

    // R4 overwrite returns former contents
    doFrame(1, 16'h0003, 16'hBEEF, mRdv, mP, mR);
    check("R4 former contents", mRdv, 16'h1234);
    check("R5 new value committed", regAt(regOut, 3), 16'hBEEF);

    // R7 out-of-range write and read
    snap = regOut;
    doFrame(1, 16'h001E, 16'h5555, mRdv, mP, mR);
    check("R7 oob write returns zero", mRdv, 16'h0000);
    check("R7 oob write not staged", {15'd0, mP}, 16'h0000);
    checks++;
    if (regOut !== snap) begin errors++; $display("FAIL R7 bank changed act=%h exp=%h", regOut[63:0], snap[63:0]); end
    doFrame(1, 16'h8018, 16'h0000, mRdv, mP, mR);
    check("R7 oob read zero", mRdv, 16'h0000);

    // R10 reserved bits ignored: write reg5 with bits 14:5 set, then read
    doFrame(1, 16'h7FE5, 16'hA5C3, mRdv, mP, mR);
    check("R10 write decoded", {15'd0, mP}, 16'h0001);
    check("R10 reg5 written", regAt(regOut, 5), 16'hA5C3);
    check("R10 aliasing reg31 region untouched", regAt(regOut, 23), 16'h0000);
    doFrame(1, 16'hFFE5, 16'h0000, mRdv, mP, mR);
    check("R10 R2 read with reserved bits", mRdv, 16'hA5C3);

    // R8 frame without command
    snap = regOut;
    doFrame(0, 16'h0000, 16'h7777, mRdv, mP, mR);
    check("R8 rdData held", mRdv, 16'hA5C3);
    check("R8 no pending", {15'd0, mP}, 16'h0000);
    checks++;
    if (regOut !== snap) begin errors++; $display("FAIL R8 bank changed act=%h exp=%h", regOut[63:0], snap[63:0]); end

    // random frames, compared each cycle by the model
    for (int f = 0; f < 300; f++) begin
      logic [DW-1:0] c;
      c = DW'($urandom);
      statusIn = 15'($urandom);
      doFrame(($urandom % 5) != 0, c, DW'($urandom), mRdv, mP, mR);
      if (($urandom % 4) == 0) begin
        roundEnd = 1'b1; @(negedge clk); roundEnd = 1'b0;
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule